// File: doc/BRIEF.md
# Abort Fault Status Capture Unit

This unit records the cause and location of memory access aborts. It holds two 8-bit status registers, one for instruction-fetch aborts and one for data-access aborts, and one 32-bit fault address register. When the fault-detection logic raises an abort strobe, the status register for that side captures the domain number and the fault type code. A data abort also captures the faulting virtual address. An instruction abort leaves the address register alone.

Software reaches the three registers through a coprocessor-style port: a register number, a sub-opcode, a write strobe and write data. The read data is a combinational function of the selected register, so a value captured at a clock edge is readable right after that edge. When an abort and a software write target the same register in the same cycle, the hardware capture wins.

Top module: `abort_status_capture`

## Requirements
- R1: A synchronous reset (rst high at a rising clock edge) clears both status registers and the fault address register to zero.
- R2: When da_strobe is high at a rising edge, the data status register becomes {da_dom, da_code} after that edge: the domain is in bits 7:4 and the fault type code in bits 3:0.
- R3: When ia_strobe is high at a rising edge, the instruction status register becomes {ia_dom, ia_code} after that edge, with the same bit layout as R2.
- R4: When da_strobe is high at a rising edge, the fault address register becomes da_vaddr after that edge.
- R5: An instruction abort changes neither the fault address register nor the data status register. A data abort does not change the instruction status register.
- R6: reg_rdata is combinational. reg_num 5 with reg_sub 0 returns the data status. reg_num 5 with reg_sub 1 returns the instruction status. reg_num 6 returns the fault address for any reg_sub.
- R7: A status read returns zero in bits 31:8. Any reg_num other than 5 or 6, and reg_num 5 with a reg_sub other than 0 or 1, reads as zero.
- R8: With reg_wr high at a rising edge, the selected register takes reg_wdata after the edge; a status register keeps reg_wdata[7:0]. A write to an unmapped selection changes no register.
- R9: If an abort strobe and a software write hit the same register at the same edge, the register takes the abort value, not the write data.
- R10: If both strobes are high at the same edge, both status registers capture their own side's values, and the address comes from the data side.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ia_strobe | input | 1 | Instruction abort occurred this cycle |
| ia_code | input | 4 | Instruction-side fault type code |
| ia_dom | input | 4 | Instruction-side domain number |
| da_strobe | input | 1 | Data abort occurred this cycle |
| da_code | input | 4 | Data-side fault type code |
| da_dom | input | 4 | Data-side domain number |
| da_vaddr | input | 32 | Virtual address of the aborted data access |
| reg_wr | input | 1 | Software write strobe |
| reg_num | input | 4 | Register number (5 status, 6 address) |
| reg_sub | input | 3 | Sub-opcode (0 data status, 1 instruction status) |
| reg_wdata | input | 32 | Software write data |
| reg_rdata | output | 32 | Read data for the current selection |

## Verification
Each capture and each software write takes effect at the rising edge where its strobe is sampled. Reads add no further delay. The bench therefore drives every input on the falling edge and lets one rising edge pass. It then sets reg_num and reg_sub and reads reg_rdata a nanosecond later, still before the next rising edge. The sweep covers every domain and code pair on each side. Each step re-reads the other side's registers to confirm they held.

// File: rtl/abrt_pkg.sv
package abrt_pkg;

    localparam int DOM_W   = 4;
    localparam int CODE_W  = 4;
    localparam int STAT_W  = DOM_W + CODE_W;
    localparam int NUM_W   = 4;
    localparam int SUB_W   = 3;
    localparam int SIDES   = 2;

    localparam logic [NUM_W-1:0] NUM_STATUS = 4'd5;
    localparam logic [NUM_W-1:0] NUM_ADDR   = 4'd6;
    localparam logic [SUB_W-1:0] SUB_DSIDE  = 3'd0;
    localparam logic [SUB_W-1:0] SUB_ISIDE  = 3'd1;

    // side index used by the generate loop
    localparam int SIDE_D = 0;
    localparam int SIDE_I = 1;

    typedef struct packed {
        logic [DOM_W-1:0]  dom;
        logic [CODE_W-1:0] code;
    } fault_stat_t;

    typedef enum logic [1:0] {
        SEL_NONE  = 2'd0,
        SEL_DSTAT = 2'd1,
        SEL_ISTAT = 2'd2,
        SEL_ADDR  = 2'd3
    } reg_sel_e;

    function automatic reg_sel_e decode_sel(input logic [NUM_W-1:0] num,
                                            input logic [SUB_W-1:0] sub);
        reg_sel_e s;
        s = SEL_NONE;
        if (num == NUM_ADDR) begin
            s = SEL_ADDR;
        end else if (num == NUM_STATUS) begin
            if (sub == SUB_DSIDE)      s = SEL_DSTAT;
            else if (sub == SUB_ISIDE) s = SEL_ISTAT;
        end
        return s;
    endfunction

endpackage

// File: rtl/abrt_stat_reg.sv
module abrt_stat_reg
    import abrt_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        cap,
    input  fault_stat_t cap_val,
    input  logic        wr,
    input  fault_stat_t wr_val,
    output fault_stat_t q
);

    always_ff @(posedge clk) begin
        if (rst)       q <= '0;
        else if (cap)  q <= cap_val;
        else if (wr)   q <= wr_val;
    end

    // R2 R3
    capture_load_chk: assert property (@(posedge clk) disable iff (rst)
        cap |=> q == $past(cap_val));

    // R9
    capture_over_write_chk: assert property (@(posedge clk) disable iff (rst)
        (cap && wr) |=> q != $past(wr_val) || $past(wr_val) == $past(cap_val));

    // R8
    sw_write_chk: assert property (@(posedge clk) disable iff (rst)
        (wr && !cap) |=> q == $past(wr_val));

    // R5
    stat_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!cap && !wr) |=> $stable(q));

endmodule

// File: rtl/abrt_addr_reg.sv
module abrt_addr_reg #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cap,
    input  logic [ADDR_W-1:0] cap_addr,
    input  logic              wr,
    input  logic [ADDR_W-1:0] wr_val,
    output logic [ADDR_W-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst)      q <= '0;
        else if (cap) q <= cap_addr;
        else if (wr)  q <= wr_val;
    end

    // R4
    addr_load_chk: assert property (@(posedge clk) disable iff (rst)
        cap |=> q == $past(cap_addr));

    // R5
    addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!cap && !wr) |=> $stable(q));

endmodule

// File: rtl/abrt_rd_mux.sv
module abrt_rd_mux
    import abrt_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  reg_sel_e          sel,
    input  fault_stat_t       dstat,
    input  fault_stat_t       istat,
    input  logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] rdata
);

    always_comb begin
        rdata = '0;
        unique case (sel)
            SEL_DSTAT: rdata[STAT_W-1:0] = dstat;
            SEL_ISTAT: rdata[STAT_W-1:0] = istat;
            SEL_ADDR:  rdata[ADDR_W-1:0] = addr;
            default:   rdata = '0;
        endcase
    end

endmodule

// File: rtl/abort_status_capture.sv
module abort_status_capture
    import abrt_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ia_strobe,
    input  logic [3:0]        ia_code,
    input  logic [3:0]        ia_dom,
    input  logic              da_strobe,
    input  logic [3:0]        da_code,
    input  logic [3:0]        da_dom,
    input  logic [ADDR_W-1:0] da_vaddr,
    input  logic              reg_wr,
    input  logic [3:0]        reg_num,
    input  logic [2:0]        reg_sub,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata
);

    reg_sel_e    sel;
    fault_stat_t side_cap_val [SIDES];
    logic        side_cap     [SIDES];
    logic        side_wr      [SIDES];
    fault_stat_t side_q       [SIDES];
    fault_stat_t wr_stat;
    logic        addr_wr;
    logic [ADDR_W-1:0] addr_q;

    assign sel     = decode_sel(reg_num, reg_sub);
    assign wr_stat = fault_stat_t'(reg_wdata[STAT_W-1:0]);
    assign addr_wr = reg_wr && (sel == SEL_ADDR);

    assign side_cap[SIDE_D]     = da_strobe;
    assign side_cap_val[SIDE_D] = '{dom: da_dom, code: da_code};
    assign side_wr[SIDE_D]      = reg_wr && (sel == SEL_DSTAT);
    assign side_cap[SIDE_I]     = ia_strobe;
    assign side_cap_val[SIDE_I] = '{dom: ia_dom, code: ia_code};
    assign side_wr[SIDE_I]      = reg_wr && (sel == SEL_ISTAT);

    for (genvar g = 0; g < SIDES; g++) begin : g_side
        abrt_stat_reg u_stat (
            .clk     (clk),
            .rst     (rst),
            .cap     (side_cap[g]),
            .cap_val (side_cap_val[g]),
            .wr      (side_wr[g]),
            .wr_val  (wr_stat),
            .q       (side_q[g])
        );
    end

    abrt_addr_reg #(.ADDR_W(ADDR_W)) u_addr (
        .clk      (clk),
        .rst      (rst),
        .cap      (da_strobe),
        .cap_addr (da_vaddr),
        .wr       (addr_wr),
        .wr_val   (reg_wdata[ADDR_W-1:0]),
        .q        (addr_q)
    );

    abrt_rd_mux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mux (
        .sel   (sel),
        .dstat (side_q[SIDE_D]),
        .istat (side_q[SIDE_I]),
        .addr  (addr_q),
        .rdata (reg_rdata)
    );

    // R7
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_num != NUM_STATUS && reg_num != NUM_ADDR) |-> reg_rdata == '0);

    // R7
    status_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_num == NUM_STATUS) |-> reg_rdata[DATA_W-1:STAT_W] == '0);

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> reg_rdata == '0);

endmodule

// File: tb/tb_abort_status_capture.sv
module tb_abort_status_capture;

    logic        clk = 1'b0;
    logic        rst;
    logic        ia_strobe, da_strobe, reg_wr;
    logic [3:0]  ia_code, ia_dom, da_code, da_dom, reg_num;
    logic [2:0]  reg_sub;
    logic [31:0] da_vaddr, reg_wdata, reg_rdata;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    abort_status_capture dut (
        .clk(clk), .rst(rst),
        .ia_strobe(ia_strobe), .ia_code(ia_code), .ia_dom(ia_dom),
        .da_strobe(da_strobe), .da_code(da_code), .da_dom(da_dom),
        .da_vaddr(da_vaddr),
        .reg_wr(reg_wr), .reg_num(reg_num), .reg_sub(reg_sub),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    task automatic idle();
        ia_strobe = 0; da_strobe = 0; reg_wr = 0;
        ia_code = 0; ia_dom = 0; da_code = 0; da_dom = 0; da_vaddr = 0;
        reg_wdata = 0;
    endtask

    // one rising edge, back at the falling edge, strobes dropped
    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        idle();
    endtask

    task automatic rd(input logic [3:0] n, input logic [2:0] s, output logic [31:0] v);
        reg_num = n; reg_sub = s;
        #1;
        v = reg_rdata;
    endtask

    task automatic wr(input logic [3:0] n, input logic [2:0] s, input logic [31:0] d);
        reg_num = n; reg_sub = s; reg_wdata = d; reg_wr = 1;
        tick();
    endtask

    logic [31:0] v, exp_d, exp_i, exp_a;

    initial begin
        #2_000_000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual running expected done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        idle(); reg_num = 0; reg_sub = 0;
        rst = 1;
        @(negedge clk); @(negedge clk);
        rst = 0;
        // R1 reset state
        rd(4'd5, 3'd0, v); check("R1", v, 0);
        rd(4'd5, 3'd1, v); check("R1", v, 0);
        rd(4'd6, 3'd0, v); check("R1", v, 0);

        // R2 R4 R5: data sweep over all domain/code pairs
        exp_i = 0;
        for (int d = 0; d < 16; d++) begin
            for (int t = 0; t < 16; t++) begin
                da_strobe = 1; da_dom = d[3:0]; da_code = t[3:0];
                exp_a = 32'h8000_0000 + d * 32'h1_0000 + t * 32'h111;
                da_vaddr = exp_a;
                exp_d = d * 16 + t;
                tick();
                rd(4'd5, 3'd0, v); check("R2", v, exp_d);
                rd(4'd6, 3'd3, v); check("R4", v, exp_a);
                rd(4'd5, 3'd1, v); check("R5", v, exp_i);
            end
        end

        // R3 R5: instruction sweep, address and data status hold
        for (int d = 0; d < 16; d++) begin
            for (int t = 0; t < 16; t++) begin
                ia_strobe = 1; ia_dom = d[3:0]; ia_code = t[3:0];
                da_vaddr = 32'hDEAD_0000 + t;
                exp_i = d * 16 + t;
                tick();
                rd(4'd5, 3'd1, v); check("R3", v, exp_i);
                rd(4'd6, 3'd0, v); check("R5", v, exp_a);
                rd(4'd5, 3'd0, v); check("R5", v, exp_d);
            end
        end

        // R7 unmapped selections and upper status bits
        for (int n = 0; n < 16; n++) begin
            for (int s = 0; s < 8; s++) begin
                rd(n[3:0], s[2:0], v);
                if (n == 6)                check("R6", v, exp_a);
                else if (n == 5 && s == 0) check("R6", v, exp_d);
                else if (n == 5 && s == 1) check("R6", v, exp_i);
                else                       check("R7", v, 0);
            end
        end

        // R8 software writes, status keeps low byte only
        wr(4'd5, 3'd0, 32'hABCD_12C3);
        rd(4'd5, 3'd0, v); check("R8", v, 32'h0000_00C3);
        rd(4'd5, 3'd1, v); check("R8", v, exp_i);
        wr(4'd5, 3'd1, 32'h5555_AA7E);
        rd(4'd5, 3'd1, v); check("R8", v, 32'h0000_007E);
        wr(4'd6, 3'd5, 32'h1234_5678);
        rd(4'd6, 3'd0, v); check("R8", v, 32'h1234_5678);
        // R8 write to unmapped selections changes nothing
        wr(4'd5, 3'd4, 32'hFFFF_FFFF);
        wr(4'd2, 3'd0, 32'hFFFF_FFFF);
        rd(4'd5, 3'd0, v); check("R8", v, 32'h0000_00C3);
        rd(4'd5, 3'd1, v); check("R8", v, 32'h0000_007E);
        rd(4'd6, 3'd0, v); check("R8", v, 32'h1234_5678);

        // R9 abort beats write to the same register
        da_strobe = 1; da_dom = 4'h9; da_code = 4'h2; da_vaddr = 32'h0BAD_F00D;
        wr(4'd5, 3'd0, 32'h0000_00FF);
        rd(4'd5, 3'd0, v); check("R9", v, 32'h0000_0092);
        rd(4'd6, 3'd0, v); check("R4", v, 32'h0BAD_F00D);
        da_strobe = 1; da_dom = 4'h3; da_code = 4'h4; da_vaddr = 32'h0000_4444;
        wr(4'd6, 3'd0, 32'hFFFF_0000);
        rd(4'd6, 3'd0, v); check("R9", v, 32'h0000_4444);
        ia_strobe = 1; ia_dom = 4'h6; ia_code = 4'h1;
        wr(4'd5, 3'd1, 32'h0000_00EE);
        rd(4'd5, 3'd1, v); check("R9", v, 32'h0000_0061);
        // R5 instruction abort plus address write: write lands
        ia_strobe = 1; ia_dom = 4'h2; ia_code = 4'h2;
        wr(4'd6, 3'd0, 32'h7777_0000);
        rd(4'd6, 3'd0, v); check("R5", v, 32'h7777_0000);

        // R10 both strobes together
        ia_strobe = 1; ia_dom = 4'hA; ia_code = 4'hB;
        da_strobe = 1; da_dom = 4'hC; da_code = 4'hD; da_vaddr = 32'hCAFE_BABE;
        tick();
        rd(4'd5, 3'd1, v); check("R10", v, 32'h0000_00AB);
        rd(4'd5, 3'd0, v); check("R10", v, 32'h0000_00CD);
        rd(4'd6, 3'd0, v); check("R10", v, 32'hCAFE_BABE);

        // R1 reset mid-run
        rst = 1; tick(); rst = 0;
        rd(4'd5, 3'd0, v); check("R1", v, 0);
        rd(4'd5, 3'd1, v); check("R1", v, 0);
        rd(4'd6, 3'd0, v); check("R1", v, 0);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule